// File: doc/BRIEF.md
# Edge-Aligned PWM Generator with Duty Saturation

This block drives one pulse-width-modulated output from a 12-bit up-counter. The counter steps from 1 up to a programmable modulus and then returns to 1, so the modulus sets the period in clock cycles. The duty value is written as a 16-bit two's-complement number. Before it is compared with the counter, it is clamped into the 12-bit counter range. Negative values become zero and positive values above the counter range become the counter maximum.

Software writes the modulus and the duty into shadow registers. Writing them changes nothing at the output. The shadow contents move into the working registers only at a reload point, and only while an arm bit is set. The arm bit drops once a reload has used it. A rate field picks how many periods pass between reload points. A sticky event flag reports each reload point, and software clears it by pulsing a clear strobe. A polarity bit picks whether the active state is driven high or low.

Top module: `edge_pwm_sat`

## Requirements
- R1: With working modulus M (1 to 4095), the counter runs 1, 2, …, M and then returns to 1, so one period is M cycles. A working modulus of 0 behaves as 1.
- R2: The output is in its active state in each cycle where the counter is less than or equal to the working duty D, so one period holds D active cycles when 0 < D < M.
- R3: A written duty in the range 0x1000 to 0x7FFF is loaded as 0xFFF.
- R4: A written duty in the range 0x8000 to 0xFFFF (negative) is loaded as 0x000.
- R5: A working duty of 0 keeps the output inactive for the whole period. A working duty greater than or equal to the working modulus keeps it active for the whole period.
- R6: Shadow modulus and duty move to the working registers only at a reload point, and only while the arm bit is 1. Otherwise the working values do not change.
- R7: The arm bit clears itself at the reload point that uses it. Later shadow writes then have no effect until the arm bit is written to 1 again.
- R8: The rate field value r (0 to 3) makes every 2^r-th period end a reload point. Writing the control register restarts this period count.
- R9: The event flag is set at every reload point. It stays set until a cycle with the clear strobe high and no reload point. A reload in the same cycle as the clear wins.
- R10: With the polarity bit at 0 the active state is high. With it at 1 the active state is low.
- R11: Reset sets the counter to 1, the working and shadow modulus and duty to 0, the rate to 0, and the arm, polarity and event flag bits to 0. The output is therefore low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized inside the block |
| mod_wr | input | 1 | Write strobe for the shadow modulus |
| mod_wdata | input | 12 | Shadow modulus value |
| duty_wr | input | 1 | Write strobe for the shadow duty |
| duty_wdata | input | 16 | Shadow duty value, two's complement |
| ctrl_wr | input | 1 | Write strobe for the control register. It also restarts the period count |
| ctrl_arm | input | 1 | Arm bit written by ctrl_wr |
| ctrl_rate | input | 2 | Reload rate field written by ctrl_wr |
| ctrl_pol | input | 1 | Polarity bit written by ctrl_wr |
| flag_clr | input | 1 | Clear strobe for the event flag |
| pwm_out | output | 1 | PWM output |
| reload_flag | output | 1 | Sticky reload event flag |

## Verification
A register write becomes visible in the cycle after its clock edge. A reload applies the new modulus and duty in the cycle after the edge that ends a period, and that cycle is the one with the counter at 1. The event flag rises in that same cycle. The output depends combinationally on registered state, so each output sample belongs to a known counter value.

The bench samples only at falling edges. It uses the first falling edge with the flag set as counter value 1, clears the flag there, and then counts active samples until the flag rises again. That single window measures both the period (or the interval between reloads) and the number of active cycles, and both are compared with values worked out from the requirements.

// File: rtl/edge_pwm_pkg.sv
package edge_pwm_pkg;
  // default geometry of the generator
  parameter int unsigned CNT_W_DEF  = 12;
  parameter int unsigned DUTY_W_DEF = 16;
  parameter int unsigned RATE_W_DEF = 2;

  // divider width needed to count up to 2^(2^RATE_W - 1) periods
  function automatic int unsigned div_width(input int unsigned rate_w);
    return (1 << rate_w) - 1;
  endfunction
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/pwm_duty_sat.sv
module pwm_duty_sat #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned DUTY_W = 16
) (
  input  logic [DUTY_W-1:0] duty_raw,
  output logic [CNT_W-1:0]  duty_sat
);
  localparam logic [CNT_W-1:0] SAT_MAX = {CNT_W{1'b1}};

  logic neg;
  logic ovf;

  assign neg = duty_raw[DUTY_W-1];

  generate
    if (DUTY_W > CNT_W + 1) begin : g_wide
      assign ovf = |duty_raw[DUTY_W-2:CNT_W];
    end else begin : g_narrow
      assign ovf = 1'b0;
    end
  endgenerate

  always_comb begin
    if (neg)      duty_sat = '0;
    else if (ovf) duty_sat = SAT_MAX;
    else          duty_sat = duty_raw[CNT_W-1:0];
  end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [CNT_W-1:0] act_mod,
  input  logic [CNT_W-1:0] act_duty,
  input  logic             pol,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] eff_mod,
  output logic             wrap,
  output logic             pwm_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             active;

  // a zero modulus behaves as a one-cycle period
  assign eff_mod = (act_mod == '0) ? ONE : act_mod;
  assign wrap    = (cnt_q >= eff_mod);

  always_comb begin
    cnt_d = cnt_q + ONE;
    if (wrap) cnt_d = ONE;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cnt_q <= ONE;
    else         cnt_q <= cnt_d;
  end

  assign active  = (cnt_q <= act_duty);
  assign pwm_out = active ^ pol;
  assign cnt     = cnt_q;
endmodule

// File: rtl/pwm_reload_ctl.sv
module pwm_reload_ctl #(
  parameter int unsigned RATE_W = 2,
  parameter int unsigned DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wrap,
  input  logic              ctrl_wr,
  input  logic              ctrl_arm,
  input  logic [RATE_W-1:0] ctrl_rate,
  input  logic              flag_clr,
  output logic              reload_pt,
  output logic              load_now,
  output logic              arm,
  output logic              flag
);
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [DIV_W-1:0]  per_q, per_d;
  logic              arm_q, arm_d;
  logic              flag_q, flag_d;
  logic [DIV_W-1:0]  last_per;

  // index of the last period in a reload group
  assign last_per  = DIV_W'((1 << rate_q) - 1);
  assign reload_pt = wrap && (per_q == last_per);
  assign load_now  = reload_pt && arm_q;

  always_comb begin
    rate_d = rate_q;
    per_d  = per_q;
    arm_d  = arm_q;
    flag_d = flag_q;

    if (wrap) per_d = reload_pt ? '0 : per_q + DIV_W'(1);
    if (reload_pt) arm_d = 1'b0;
    if (ctrl_wr) begin
      rate_d = ctrl_rate;
      per_d  = '0;
      arm_d  = ctrl_arm;
    end

    if (reload_pt)     flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rate_q <= '0;
      per_q  <= '0;
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rate_q <= rate_d;
      per_q  <= per_d;
      arm_q  <= arm_d;
      flag_q <= flag_d;
    end
  end

  assign arm  = arm_q;
  assign flag = flag_q;
endmodule

// File: rtl/edge_pwm_sat.sv
module edge_pwm_sat
  import edge_pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned DUTY_W = DUTY_W_DEF,
  parameter int unsigned RATE_W = RATE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_wr,
  input  logic [CNT_W-1:0]  mod_wdata,
  input  logic              duty_wr,
  input  logic [DUTY_W-1:0] duty_wdata,
  input  logic              ctrl_wr,
  input  logic              ctrl_arm,
  input  logic [RATE_W-1:0] ctrl_rate,
  input  logic              ctrl_pol,
  input  logic              flag_clr,
  output logic              pwm_out,
  output logic              reload_flag
);
  localparam int unsigned DIV_W = div_width(RATE_W);

  logic              rst_sn;
  logic [CNT_W-1:0]  buf_mod_q, buf_mod_d;
  logic [DUTY_W-1:0] buf_duty_q, buf_duty_d;
  logic [CNT_W-1:0]  act_mod_q, act_mod_d;
  logic [CNT_W-1:0]  act_duty_q, act_duty_d;
  logic              pol_q, pol_d;
  logic [CNT_W-1:0]  duty_sat;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  eff_mod;
  logic              wrap;
  logic              reload_pt;
  logic              load_now;
  logic              arm;

  pwm_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pwm_duty_sat #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_sat (
    .duty_raw (buf_duty_q),
    .duty_sat (duty_sat)
  );

  pwm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .act_mod  (act_mod_q),
    .act_duty (act_duty_q),
    .pol      (pol_q),
    .cnt      (cnt),
    .eff_mod  (eff_mod),
    .wrap     (wrap),
    .pwm_out  (pwm_out)
  );

  pwm_reload_ctl #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_rld (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .wrap      (wrap),
    .ctrl_wr   (ctrl_wr),
    .ctrl_arm  (ctrl_arm),
    .ctrl_rate (ctrl_rate),
    .flag_clr  (flag_clr),
    .reload_pt (reload_pt),
    .load_now  (load_now),
    .arm       (arm),
    .flag      (reload_flag)
  );

  // shadow, working and polarity next state
  always_comb begin
    buf_mod_d  = buf_mod_q;
    buf_duty_d = buf_duty_q;
    act_mod_d  = act_mod_q;
    act_duty_d = act_duty_q;
    pol_d      = pol_q;
    if (mod_wr)  buf_mod_d  = mod_wdata;
    if (duty_wr) buf_duty_d = duty_wdata;
    if (ctrl_wr) pol_d      = ctrl_pol;
    if (load_now) begin
      act_mod_d  = buf_mod_q;
      act_duty_d = duty_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      buf_mod_q  <= '0;
      buf_duty_q <= '0;
      act_mod_q  <= '0;
      act_duty_q <= '0;
      pol_q      <= 1'b0;
    end else begin
      buf_mod_q  <= buf_mod_d;
      buf_duty_q <= buf_duty_d;
      act_mod_q  <= act_mod_d;
      act_duty_q <= act_duty_d;
      pol_q      <= pol_d;
    end
  end
endmodule

// File: rtl/edge_pwm_sat_chk.sv
module edge_pwm_sat_chk #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned DUTY_W = 16
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  eff_mod,
  input logic [CNT_W-1:0]  act_mod_q,
  input logic [CNT_W-1:0]  act_duty_q,
  input logic [DUTY_W-1:0] buf_duty_q,
  input logic              pol_q,
  input logic              reload_pt,
  input logic              load_now,
  input logic              arm,
  input logic              ctrl_wr,
  input logic              flag_clr,
  input logic              reload_flag,
  input logic              pwm_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R1: counter stays inside 1..modulus
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt >= ONE) && (cnt <= eff_mod));

  // R1: counter returns to 1 after reaching the modulus
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt >= eff_mod) |=> (cnt == ONE));

  // R1: counter steps by one below the modulus
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (cnt < eff_mod) |=> (cnt == $past(cnt) + ONE));

  // R3: positive overflow loads the top of the range
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (load_now && !buf_duty_q[DUTY_W-1] && (buf_duty_q[DUTY_W-2:CNT_W] != '0))
    |=> (act_duty_q == {CNT_W{1'b1}}));

  // R4: negative values load zero
  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (load_now && buf_duty_q[DUTY_W-1]) |=> (act_duty_q == '0));

  // R5: zero duty is never active, full duty always active
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (act_duty_q == '0) |-> (pwm_out == pol_q));
  p_full_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (act_duty_q >= eff_mod) |-> (pwm_out != pol_q));

  // R6: working registers change only on an armed reload
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    !load_now |=> ($stable(act_mod_q) && $stable(act_duty_q)));

  // R7: arm drops after use
  p_arm_clr_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (load_now && !ctrl_wr) |=> !arm);

  // R9: flag set, kept and cleared
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    reload_pt |=> reload_flag);
  p_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (reload_flag && !flag_clr) |=> reload_flag);
  p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (flag_clr && !reload_pt) |=> !reload_flag);

  // R11: quiet outputs while held in reset
  always @(negedge clk) begin
    if (!rst_sn) begin
      p_reset_r11: assert (!pwm_out && !reload_flag && (cnt == ONE));
    end
  end
endmodule

bind edge_pwm_sat edge_pwm_sat_chk #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .cnt         (cnt),
  .eff_mod     (eff_mod),
  .act_mod_q   (act_mod_q),
  .act_duty_q  (act_duty_q),
  .buf_duty_q  (buf_duty_q),
  .pol_q       (pol_q),
  .reload_pt   (reload_pt),
  .load_now    (load_now),
  .arm         (arm),
  .ctrl_wr     (ctrl_wr),
  .flag_clr    (flag_clr),
  .reload_flag (reload_flag),
  .pwm_out     (pwm_out)
);

// File: tb/edge_pwm_sat_test.sv
`timescale 1ns/1ps
module edge_pwm_sat_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mod_wr, duty_wr, ctrl_wr, ctrl_arm, ctrl_pol, flag_clr;
  logic [11:0] mod_wdata;
  logic [15:0] duty_wdata;
  logic [1:0]  ctrl_rate;
  logic        pwm_out, reload_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  edge_pwm_sat uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_wr      (mod_wr),
    .mod_wdata   (mod_wdata),
    .duty_wr     (duty_wr),
    .duty_wdata  (duty_wdata),
    .ctrl_wr     (ctrl_wr),
    .ctrl_arm    (ctrl_arm),
    .ctrl_rate   (ctrl_rate),
    .ctrl_pol    (ctrl_pol),
    .flag_clr    (flag_clr),
    .pwm_out     (pwm_out),
    .reload_flag (reload_flag)
  );

  typedef struct packed {
    logic [15:0] duty;
    logic [11:0] modv;
    logic        pol;
    logic [12:0] hi;
    logic [12:0] per;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{16'h0003, 12'd8,    1'b0, 13'd3,    13'd8},    // R2 mid duty
    '{16'h0000, 12'd5,    1'b0, 13'd0,    13'd5},    // R5 zero duty
    '{16'h8000, 12'd6,    1'b0, 13'd0,    13'd6},    // R4 most negative
    '{16'hFFFF, 12'd4,    1'b0, 13'd0,    13'd4},    // R4 minus one
    '{16'h1000, 12'd7,    1'b0, 13'd7,    13'd7},    // R3 lowest overflow
    '{16'h7FFF, 12'd3,    1'b0, 13'd3,    13'd3},    // R3 highest overflow
    '{16'h0009, 12'd9,    1'b0, 13'd9,    13'd9},    // R5 duty equals modulus
    '{16'h1234, 12'hFFF,  1'b0, 13'd4095, 13'd4095}, // R3 clamp to 0xFFF
    '{16'h0FFE, 12'hFFF,  1'b0, 13'd4094, 13'd4095}, // R2 near full
    '{16'h0002, 12'd0,    1'b0, 13'd1,    13'd1},    // R1 zero modulus
    '{16'h0004, 12'd10,   1'b1, 13'd6,    13'd10},   // R10 inverted
    '{16'h0006, 12'd1,    1'b0, 13'd1,    13'd1}     // R1 one-cycle period
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic write_regs(input bit wm, input logic [11:0] m,
                            input bit wd, input logic [15:0] d,
                            input bit wc, input bit arm,
                            input logic [1:0] rate, input bit pol);
    mod_wr = wm; mod_wdata = m;
    duty_wr = wd; duty_wdata = d;
    ctrl_wr = wc; ctrl_arm = arm; ctrl_rate = rate; ctrl_pol = pol;
    @(negedge clk);
    mod_wr = 1'b0; duty_wr = 1'b0; ctrl_wr = 1'b0;
  endtask

  // aligns on a reload, then measures cycles to the next reload and active samples
  task automatic observe(output int hi, output int per);
    int guard;
    hi = 0; per = 0; guard = 0;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    while (!reload_flag && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    hi = hi + int'(pwm_out);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    per = 1;
    while (!reload_flag && per < 20000) begin
      hi = hi + int'(pwm_out);
      @(negedge clk);
      per++;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, per;
    rst_n = 1'b0;
    mod_wr = 1'b0; duty_wr = 1'b0; ctrl_wr = 1'b0; flag_clr = 1'b0;
    ctrl_arm = 1'b0; ctrl_pol = 1'b0; ctrl_rate = 2'd0;
    mod_wdata = '0; duty_wdata = '0;

    // R11: outputs quiet during reset
    repeat (3) @(negedge clk);
    check("R11 pwm in reset", int'(pwm_out), 0);
    check("R11 flag in reset", int'(reload_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: period of one cycle reloads every cycle after reset
    check("R9 flag after reset", int'(reload_flag), 1);
    check("R11 pwm after reset", int'(pwm_out), 0);

    // table of armed loads, rate 0
    for (int i = 0; i < NV; i++) begin
      write_regs(1'b1, VEC[i].modv, 1'b1, VEC[i].duty, 1'b1, 1'b1, 2'd0, VEC[i].pol);
      observe(hi, per);
      check($sformatf("R1 period vec %0d", i), per, int'(VEC[i].per));
      check($sformatf("R2/R3/R4/R5/R10 active vec %0d", i), hi, int'(VEC[i].hi));
    end

    // R7, R6: arm was consumed, shadow writes stay out
    write_regs(1'b1, 12'd5, 1'b1, 16'h0002, 1'b0, 1'b0, 2'd0, 1'b0);
    repeat (6) @(negedge clk);
    observe(hi, per);
    check("R7 unarmed period", per, 1);
    check("R6 unarmed active", hi, 1);
    write_regs(1'b0, 12'd0, 1'b0, 16'h0, 1'b1, 1'b1, 2'd0, 1'b0);
    observe(hi, per);
    check("R6 armed period", per, 5);
    check("R6 armed active", hi, 2);

    // R8: rate field spacing with modulus 5, duty 2
    for (int r = 1; r < 4; r++) begin
      write_regs(1'b0, 12'd0, 1'b0, 16'h0, 1'b1, 1'b0, 2'(r), 1'b0);
      observe(hi, per);
      check($sformatf("R8 reload spacing rate %0d", r), per, 5 * (1 << r));
      check($sformatf("R8 active over group rate %0d", r), hi, 2 * (1 << r));
    end

    // R9: flag is sticky and clears on strobe (rate 3, 40-cycle spacing)
    repeat (5) @(negedge clk);
    check("R9 flag sticky", int'(reload_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R9 flag cleared", int'(reload_flag), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule